// File: doc/BRIEF.md
# Reorder Sequence Group Allocator

This block hands out reorder-buffer capacity to ordered queues. The capacity sits in a fixed set of sequence-number groups of equal size, 1024 entries each by default. A group serves one slot size at a time. It is split evenly into a power-of-two number of slots, from one slot of 1024 entries down to 32 slots of 32 entries. A group is unconfigured until it gets its first allocation, and that request fixes its slot size. From then on the group only serves requests for that same size. It becomes unconfigured again once its last occupied slot is released.

A configuration agent sends one command at a time over a valid/ready request channel. The command is allocate (queue ID plus entries per queue), free (group index plus slot index) or clear-all. The block answers on a registered response channel, one cycle after it accepts the request. The response carries a status, the echoed queue ID, and, for an allocation that took a slot, the group and slot indices. An allocation for size zero is for an unordered queue: it succeeds and takes no slot.

Top module: `seqgrp_alloc`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and every group is unconfigured, so the first legal allocation gets group 0, slot 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its response appears with `rsp_valid`=1 after that edge. While `rsp_valid`=1 and `rsp_ready`=0, the response holds steady and `req_ready` is 0.
- R3: An allocation of size 0 returns status OK (code 0) with `rsp_ordered`=0 and changes no group.
- R4: An allocation whose size is not a power of two in the range 32 to 1024 returns BADARG (code 2) and changes no group. Opcode 3 also returns BADARG. Opcodes are allocate=0, free=1, clear=2.
- R5: A legal allocation first takes the lowest free slot of the lowest-numbered configured group whose slot size matches. It returns OK with `rsp_ordered`=1 and that group and slot.
- R6: If no configured group of that size has a free slot, the lowest-numbered unconfigured group is set to the requested size, and its slot 0 is granted.
- R7: If every group is configured and none of the requested size has room, the response is NOSPACE (code 1) and no group changes.
- R8: A group of slot size S holds exactly 1024/S queues, in slots 0 to 1024/S-1. The next allocation of that size goes to another group.
- R9: A free of an occupied slot returns OK and releases the slot. The next allocation of that size reuses it as the lowest free index.
- R10: Freeing the last occupied slot of a group returns the group to unconfigured, so it can then take a different size.
- R11: A free that names a slot that is not occupied, including one beyond the group's slot count, returns BADARG and changes nothing.
- R12: A clear command returns OK and makes every group unconfigured and empty.
- R13: Every response echoes the queue ID of its request on `rsp_qid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 allocate, 1 free, 2 clear, 3 reserved |
| req_qid | input | QID_W (6) | Queue ID, echoed in the response |
| req_size | input | SIZE_W (11) | Requested entries per queue (allocate) |
| req_grp | input | GRP_W (1) | Group index (free) |
| req_slot | input | SLOT_W (5) | Slot index (free) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_status | output | 2 | 0 OK, 1 NOSPACE, 2 BADARG |
| rsp_qid | output | QID_W (6) | Echoed queue ID |
| rsp_ordered | output | 1 | A slot was granted or released |
| rsp_grp | output | GRP_W (1) | Group index of the granted or released slot |
| rsp_slot | output | SLOT_W (5) | Slot index of the granted or released slot |

## Verification
Allocation is driven with runs of one size that fill a group to capacity at both extremes: four slots of 256 and thirty-two slots of 32. These runs show whether slot counting follows the configured size and whether overflow moves to the next group. Mismatched sizes, issued after both groups are configured, separate the refusal path from the claim path. Size-zero, illegal-size and bad-opcode requests, each followed by an ordinary allocation, show that they leave no trace. Frees of occupied, unoccupied and out-of-range slots, followed by release of a whole group and a new size in it, test slot reuse and the return to the unconfigured state.

// File: rtl/seqgrp_pkg.sv
package seqgrp_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_FREE  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NOSPACE = 2'd1,
    ST_BADARG  = 2'd2
  } status_e;

  // legal slot size: single bit set, within [lo, hi]
  function automatic bit size_legal(int unsigned s, int unsigned lo, int unsigned hi);
    return (s >= lo) && (s <= hi) && ((s & (s - 1)) == 0);
  endfunction

  // index of the highest set bit (log2 for a power of two)
  function automatic int unsigned size_log2(int unsigned s);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (s[i]) r = i;
    end
    return r;
  endfunction

  // number of slots a group offers at slot size 2**lg
  function automatic int unsigned slots_for(int unsigned entries, int unsigned lg);
    return entries >> lg;
  endfunction

endpackage

// File: rtl/seqgrp_group.sv
module seqgrp_group
  import seqgrp_pkg::*;
#(
  parameter int unsigned ENTRIES   = 1024,
  parameter int unsigned MAX_SLOTS = 32,
  parameter int unsigned LOG_W     = 4,
  parameter int unsigned SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_all,
  input  logic                 alloc_en,
  input  logic [LOG_W-1:0]     alloc_log,
  input  logic                 free_en,
  input  logic [SLOT_W-1:0]    free_slot,
  output logic                 cfg_vld,
  output logic [LOG_W-1:0]     cfg_log,
  output logic [MAX_SLOTS-1:0] occ,
  output logic                 has_free,
  output logic [SLOT_W-1:0]    free_idx
);

  logic [MAX_SLOTS-1:0] usable;
  logic [MAX_SLOTS-1:0] avail;
  logic [MAX_SLOTS-1:0] occ_after_free;

  always_comb begin
    for (int i = 0; i < int'(MAX_SLOTS); i++) begin
      usable[i] = cfg_vld && (i < int'(slots_for(ENTRIES, 32'(cfg_log))));
    end
  end

  assign avail    = usable & ~occ;
  assign has_free = |avail;

  always_comb begin
    free_idx = '0;
    for (int i = int'(MAX_SLOTS) - 1; i >= 0; i--) begin
      if (avail[i]) free_idx = SLOT_W'(i);
    end
  end

  assign occ_after_free = occ & ~(MAX_SLOTS'(1) << free_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_vld <= 1'b0;
      cfg_log <= '0;
      occ     <= '0;
    end else if (clr_all) begin
      cfg_vld <= 1'b0;
      cfg_log <= '0;
      occ     <= '0;
    end else if (alloc_en) begin
      if (!cfg_vld) begin
        cfg_vld <= 1'b1;
        cfg_log <= alloc_log;
      end
      occ[free_idx] <= 1'b1;
    end else if (free_en) begin
      occ <= occ_after_free;
      if (occ_after_free == '0) cfg_vld <= 1'b0;
    end
  end

  // R8
  occ_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ & ~usable) == '0);

  // R10
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_vld |-> (occ == '0));

  // R5
  alloc_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !clr_all) |=> ($countones(occ) == $past($countones(occ)) + 1));

endmodule

// File: rtl/seqgrp_pick.sv
module seqgrp_pick #(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned LOG_W      = 4,
  parameter int unsigned GRP_W      = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_GROUPS-1:0]            cfg_vld,
  input  logic [NUM_GROUPS-1:0][LOG_W-1:0] cfg_log,
  input  logic [NUM_GROUPS-1:0]            has_free,
  input  logic [LOG_W-1:0]                 want_log,
  output logic                             found,
  output logic                             pick_new,
  output logic [GRP_W-1:0]                 pick_grp
);

  logic [NUM_GROUPS-1:0] match;
  logic [NUM_GROUPS-1:0] idle;
  logic [GRP_W-1:0]      match_grp;
  logic [GRP_W-1:0]      idle_grp;

  always_comb begin
    match_grp = '0;
    idle_grp  = '0;
    for (int g = int'(NUM_GROUPS) - 1; g >= 0; g--) begin
      match[g] = cfg_vld[g] && (cfg_log[g] == want_log) && has_free[g];
      idle[g]  = !cfg_vld[g];
      if (match[g]) match_grp = GRP_W'(g);
      if (idle[g])  idle_grp  = GRP_W'(g);
    end
  end

  assign found    = (|match) || (|idle);
  assign pick_new = !(|match);
  assign pick_grp = (|match) ? match_grp : idle_grp;

  // R5
  match_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|match) |-> (!pick_new && cfg_vld[pick_grp] && (cfg_log[pick_grp] == want_log)));

  // R6
  new_is_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found && pick_new) |-> !cfg_vld[pick_grp]);

endmodule

// File: rtl/seqgrp_alloc.sv
module seqgrp_alloc
  import seqgrp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS    = 2,
  parameter int unsigned GROUP_ENTRIES = 1024,
  parameter int unsigned MIN_SIZE      = 32,
  parameter int unsigned QID_W         = 6,
  localparam int unsigned SIZE_W    = $clog2(GROUP_ENTRIES) + 1,
  localparam int unsigned MAX_SLOTS = GROUP_ENTRIES / MIN_SIZE,
  localparam int unsigned SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int unsigned GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [QID_W-1:0]  req_qid,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [GRP_W-1:0]  req_grp,
  input  logic [SLOT_W-1:0] req_slot,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [QID_W-1:0]  rsp_qid,
  output logic              rsp_ordered,
  output logic [GRP_W-1:0]  rsp_grp,
  output logic [SLOT_W-1:0] rsp_slot
);

  localparam int unsigned LOG_W = $clog2(SIZE_W);

  logic                                 accept;
  logic [LOG_W-1:0]                     want_log;
  logic                                 size_ok;
  logic                                 size_zero;
  logic [NUM_GROUPS-1:0]                cfg_vld;
  logic [NUM_GROUPS-1:0][LOG_W-1:0]     cfg_log;
  logic [NUM_GROUPS-1:0][MAX_SLOTS-1:0] occ;
  logic [NUM_GROUPS-1:0]                has_free;
  logic [NUM_GROUPS-1:0][SLOT_W-1:0]    free_idx;
  logic                                 found;
  logic                                 pick_new;
  logic [GRP_W-1:0]                     pick_grp;
  logic                                 grp_ok;
  logic                                 free_hit;
  logic                                 alloc_go;
  logic                                 free_go;
  logic                                 clear_go;
  status_e                              nxt_status;
  logic                                 nxt_ordered;
  logic [GRP_W-1:0]                     nxt_grp;
  logic [SLOT_W-1:0]                    nxt_slot;
  op_e                                  op;

  assign op        = op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign size_zero = (req_size == '0);
  assign size_ok   = size_legal(32'(req_size), MIN_SIZE, GROUP_ENTRIES);
  assign want_log  = LOG_W'(size_log2(32'(req_size)));
  assign grp_ok    = 32'(req_grp) < NUM_GROUPS;
  assign free_hit  = grp_ok && occ[req_grp][req_slot];

  seqgrp_pick #(
    .NUM_GROUPS (NUM_GROUPS),
    .LOG_W      (LOG_W),
    .GRP_W      (GRP_W)
  ) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_vld  (cfg_vld),
    .cfg_log  (cfg_log),
    .has_free (has_free),
    .want_log (want_log),
    .found    (found),
    .pick_new (pick_new),
    .pick_grp (pick_grp)
  );

  always_comb begin
    nxt_status  = ST_OK;
    nxt_ordered = 1'b0;
    nxt_grp     = '0;
    nxt_slot    = '0;
    alloc_go    = 1'b0;
    free_go     = 1'b0;
    clear_go    = 1'b0;
    unique case (op)
      OP_ALLOC: begin
        if (size_zero) begin
          nxt_status = ST_OK;
        end else if (!size_ok) begin
          nxt_status = ST_BADARG;
        end else if (found) begin
          nxt_status  = ST_OK;
          nxt_ordered = 1'b1;
          nxt_grp     = pick_grp;
          nxt_slot    = free_idx[pick_grp];
          alloc_go    = accept;
        end else begin
          nxt_status = ST_NOSPACE;
        end
      end
      OP_FREE: begin
        if (free_hit) begin
          nxt_status  = ST_OK;
          nxt_ordered = 1'b1;
          nxt_grp     = req_grp;
          nxt_slot    = req_slot;
          free_go     = accept;
        end else begin
          nxt_status = ST_BADARG;
        end
      end
      OP_CLEAR: begin
        nxt_status = ST_OK;
        clear_go   = accept;
      end
      default: nxt_status = ST_BADARG;
    endcase
  end

  for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_grp
    seqgrp_group #(
      .ENTRIES   (GROUP_ENTRIES),
      .MAX_SLOTS (MAX_SLOTS),
      .LOG_W     (LOG_W),
      .SLOT_W    (SLOT_W)
    ) u_group (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all   (clear_go),
      .alloc_en  (alloc_go && (pick_grp == GRP_W'(g))),
      .alloc_log (want_log),
      .free_en   (free_go && (req_grp == GRP_W'(g))),
      .free_slot (req_slot),
      .cfg_vld   (cfg_vld[g]),
      .cfg_log   (cfg_log[g]),
      .occ       (occ[g]),
      .has_free  (has_free[g]),
      .free_idx  (free_idx[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_status  <= ST_OK;
      rsp_qid     <= '0;
      rsp_ordered <= 1'b0;
      rsp_grp     <= '0;
      rsp_slot    <= '0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_status  <= nxt_status;
      rsp_qid     <= req_qid;
      rsp_ordered <= nxt_ordered;
      rsp_grp     <= nxt_grp;
      rsp_slot    <= nxt_slot;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_slot) && $stable(rsp_qid)));

  // R7
  nospace_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_ALLOC && size_ok && !found) |=> ($stable(occ) && $stable(cfg_vld)));

  // R4
  badarg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && nxt_status == ST_BADARG) |=> ($stable(occ) && $stable(cfg_vld)));

  // R3
  zero_size_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_ALLOC && size_zero) |=> ($stable(occ) && $stable(cfg_vld) && !rsp_ordered));

endmodule

// File: tb/seqgrp_alloc_tb.sv
module seqgrp_alloc_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [5:0]  req_qid = '0;
  logic [10:0] req_size = '0;
  logic [0:0]  req_grp = '0;
  logic [4:0]  req_slot = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_status;
  logic [5:0]  rsp_qid;
  logic        rsp_ordered;
  logic [0:0]  rsp_grp;
  logic [4:0]  rsp_slot;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int r_st, r_ord, r_grp, r_slot, r_qid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seqgrp_alloc u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_qid(req_qid), .req_size(req_size), .req_grp(req_grp), .req_slot(req_slot),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_qid(rsp_qid), .rsp_ordered(rsp_ordered), .rsp_grp(rsp_grp), .rsp_slot(rsp_slot)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one request, response captured one negedge after acceptance
  task automatic send(int op, int qid, int size, int grp, int slot);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_qid   = 6'(qid);
    req_size  = 11'(size);
    req_grp   = 1'(grp);
    req_slot  = 5'(slot);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid after accept", int'(rsp_valid), 1);
    r_st   = int'(rsp_status);
    r_ord  = int'(rsp_ordered);
    r_grp  = int'(rsp_grp);
    r_slot = int'(rsp_slot);
    r_qid  = int'(rsp_qid);
  endtask

  task automatic alloc_exp(string tag, int qid, int size, int st, int grp, int slot);
    send(0, qid, size, 0, 0);
    chk({tag, " status"}, r_st, st);
    if (st == 0) begin
      chk({tag, " ordered"}, r_ord, 1);
      chk({tag, " grp"}, r_grp, grp);
      chk({tag, " slot"}, r_slot, slot);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    send(0, 7, 0, 0, 0);
    chk("R2 req_ready low while held", int'(req_ready), 0);
    @(negedge clk);
    chk("R2 rsp_valid held", int'(rsp_valid), 1);
    chk("R13 qid held", int'(rsp_qid), 7);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 rsp_valid drops after consume", int'(rsp_valid), 0);
  endtask

  task automatic t_first_and_fill();
    send(0, 5, 256, 0, 0);
    chk("R1 first status", r_st, 0);
    chk("R6 first grp", r_grp, 0);
    chk("R1 first slot", r_slot, 0);
    chk("R13 qid echo", r_qid, 5);
    for (int i = 1; i < 4; i++) alloc_exp("R5 fill 256", i, 256, 0, 0, i);
    alloc_exp("R8 overflow to next group", 9, 256, 0, 1, 0);
  endtask

  task automatic t_nospace();
    alloc_exp("R7 mismatch size", 10, 64, 1, 0, 0);
    alloc_exp("R7 state unchanged", 11, 256, 0, 1, 1);
  endtask

  task automatic t_zero();
    send(0, 12, 0, 0, 0);
    chk("R3 zero status", r_st, 0);
    chk("R3 zero unordered", r_ord, 0);
    alloc_exp("R3 no slot used", 13, 256, 0, 1, 2);
  endtask

  task automatic t_bad();
    alloc_exp("R4 size 100", 14, 100, 2, 0, 0);
    alloc_exp("R4 size 16", 15, 16, 2, 0, 0);
    send(3, 16, 256, 0, 0);
    chk("R4 reserved opcode", r_st, 2);
    alloc_exp("R4 nothing changed", 17, 256, 0, 1, 3);
    alloc_exp("R7 all full", 18, 256, 1, 0, 0);
  endtask

  task automatic t_free();
    send(1, 0, 0, 0, 1);
    chk("R9 free status", r_st, 0);
    alloc_exp("R9 slot reused", 19, 256, 0, 0, 1);
    send(1, 0, 0, 0, 5);
    chk("R11 free out of range", r_st, 2);
    send(1, 0, 0, 1, 3);
    chk("R9 free g1 s3", r_st, 0);
    send(1, 0, 0, 1, 3);
    chk("R11 double free", r_st, 2);
  endtask

  task automatic t_release();
    for (int i = 0; i < 4; i++) begin
      send(1, 0, 0, 0, i);
      chk("R10 free g0 slot", r_st, 0);
    end
    alloc_exp("R10 group takes new size", 20, 1024, 0, 0, 0);
    alloc_exp("R8 1024 group holds one", 21, 1024, 1, 0, 0);
  endtask

  task automatic t_clear();
    send(2, 0, 0, 0, 0);
    chk("R12 clear status", r_st, 0);
    for (int i = 0; i < 32; i++) alloc_exp("R8 fill 32", i, 32, 0, 0, i);
    alloc_exp("R12 g1 free after clear", 33, 32, 0, 1, 0);
    alloc_exp("R7 64 refused", 34, 64, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_backpressure();
    t_first_and_fill();
    t_nospace();
    t_zero();
    t_bad();
    t_free();
    t_release();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule